// File: doc/BRIEF.md
# PLL Factor Search Engine

This block searches for the pair of integer factors, a pre-divider M and a multiplier N, that makes a synthesized frequency of (reference × N) / M land as close as possible to a requested target while staying strictly below it. It is meant to sit next to a display clock generator: a control sequencer pulses a start request with the wanted dot-clock frequency, waits for completion, and then programs its PLL and divider from the factors the block returns.

The search is run twice on a single sweep engine. The first pass uses a 3 MHz reference and the second a 6 MHz reference. Within a pass, M steps from 1 to 15 and, for each M, N steps from 9 to 127. Each candidate is evaluated in one clock cycle. The exact truncated quotient is kept by stepping a quotient and remainder pair, and that pair is seeded by an iterative divider once per M. When both passes are finished, the higher of the two pass results is reported, together with a flag that tells which reference produced it.

Top module: `pll_factor_search`

## Requirements
- R1: After reset, busy_o, done_o, dbl_o, m_o, n_o and freq_o are all zero.
- R2: Every reported result satisfies freq_o = floor(n_o × R / m_o), with R = 3,000,000 when dbl_o is 0 and R = 6,000,000 when dbl_o is 1, 1 ≤ m_o ≤ 15 and 9 ≤ n_o ≤ 127.
- R3: Only candidates strictly below the target are accepted. A candidate that equals the target exactly is never reported.
- R4: Within a pass, the result is the largest candidate below the target. On equal candidates, the one with the smallest M, then the smallest N, is kept.
- R5: A pass that accepts no candidate yields M = 0, N = 0 and a frequency of 0. If both passes yield nothing, m_o, n_o and freq_o are 0 and dbl_o is 0.
- R6: The doubled-reference result is chosen (dbl_o = 1) only when its frequency is strictly greater than the single-reference result. On equal frequencies, the single-reference result is reported.
- R7: target_i is captured in the cycle start_i is sampled while idle. A start_i pulse during a search is ignored and does not change the result.
- R8: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse, and the outputs then hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| target_i | input | 64 | Target frequency in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| m_o | output | 4 | Chosen pre-divider M |
| n_o | output | 7 | Chosen multiplier N |
| freq_o | output | 64 | Achieved frequency in Hz |
| dbl_o | output | 1 | 1 when the 6 MHz reference was chosen |

## Verification
On every cycle the assertions check the following: the divider remainder stays below its divisor, the sweep holds M inside its range, a held best candidate is below the latched target, an empty pass carries a zero frequency, done lasts one cycle, the target is stable against a start during a search, and a doubled result beats the first pass. The scenarios must show the things that depend on the whole search. These are that the reported factors are the closest from below, that exact matches are skipped, that equal results across the passes go to the single reference, and that no-result targets return zeros. The bench compares these against its own exhaustive model.

// File: rtl/pfs_pkg.sv
// Shared state encodings for the PLL factor search engine.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pfs_pkg;
    typedef enum logic [1:0] {
        SW_IDLE,
        SW_DIV_GO,
        SW_DIV_WAIT,
        SW_STEP
    } sweep_state_t;

    typedef enum logic [1:0] {
        TP_IDLE,
        TP_PASS1,
        TP_PASS2
    } top_state_t;
endpackage

// File: rtl/pfs_divider.sv
// Restoring divider that takes DVD_W cycles to produce quotient and remainder.
// Assumes the divisor is non-zero. go_i restarts it at any time.
module pfs_divider #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quot_o,
    output logic [DVS_W-1:0] rem_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [DVS_W-1:0] dvs;
    logic [DVS_W:0]   trial;
    logic             fits;

    // Next partial remainder and whether the divisor fits into it
    assign trial = {rem_o, quot_o[DVD_W-1]};
    assign fits  = (trial >= {1'b0, dvs});

    // Shift-subtract iteration, one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            run    <= 1'b0;
            dvs    <= '0;
            quot_o <= '0;
            rem_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                quot_o <= dividend_i;
                rem_o  <= '0;
                dvs    <= divisor_i;
                cnt    <= CNT_W'(DVD_W);
                run    <= 1'b1;
            end else if (run) begin
                quot_o <= {quot_o[DVD_W-2:0], fits};
                rem_o  <= fits ? DVS_W'(trial - {1'b0, dvs}) : trial[DVS_W-1:0];
                cnt    <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run    <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R2
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < dvs));
endmodule

// File: rtl/pfs_sweep.sv
// One search pass: sweeps M (outer) and N (inner) and keeps the candidate
// floor(N*ref/M) closest to the target from strictly below.
// Per M the divider gives ref/M, and the quotient and remainder are then
// stepped once per N, so each candidate costs one cycle.
// Assumes M_MIN >= 1 and that N_MAX*ref fits in FREQ_W bits.
module pfs_sweep
    import pfs_pkg::*;
#(
    parameter int FREQ_W = 64,
    parameter int REF_W  = 32,
    parameter int M_MIN  = 1,
    parameter int M_MAX  = 15,
    parameter int N_MIN  = 9,
    parameter int N_MAX  = 127,
    parameter int M_W    = 4,
    parameter int N_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [REF_W-1:0]  ref_i,
    input  logic [FREQ_W-1:0] target_i,
    output logic              done_o,
    output logic [M_W-1:0]    m_o,
    output logic [N_W-1:0]    n_o,
    output logic [FREQ_W-1:0] freq_o
);
    sweep_state_t      state;
    logic [REF_W-1:0]  ref_q;
    logic [FREQ_W-1:0] tgt;
    logic [FREQ_W-1:0] best;
    logic [M_W-1:0]    m;
    logic [N_W-1:0]    n;
    logic [FREQ_W-1:0] q;
    logic [M_W-1:0]    r;
    logic [REF_W-1:0]  qs;
    logic [M_W-1:0]    rs;

    logic              div_go, div_done;
    logic [REF_W-1:0]  div_q;
    logic [M_W-1:0]    div_r;

    logic [M_W:0]      r_sum;
    logic              wrap;
    logic [M_W-1:0]    r_next;
    logic [FREQ_W-1:0] q_next;
    logic [N_W-1:0]    n_next;
    logic [FREQ_W-1:0] diff;
    logic              take;

    assign div_go = (state == SW_DIV_GO);

    pfs_divider #(.DVD_W(REF_W), .DVS_W(M_W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (ref_q),
        .divisor_i  (m),
        .done_o     (div_done),
        .quot_o     (div_q),
        .rem_o      (div_r)
    );

    // Step the candidate from N to N+1 and decide whether it becomes the best
    always_comb begin
        r_sum  = {1'b0, r} + {1'b0, rs};
        wrap   = (r_sum >= {1'b0, m});
        r_next = wrap ? M_W'(r_sum - {1'b0, m}) : r_sum[M_W-1:0];
        q_next = q + FREQ_W'(qs) + FREQ_W'(wrap);
        n_next = n + 1'b1;
        diff   = tgt - q_next;
        take   = (n_next >= N_W'(N_MIN)) && (q_next < tgt) && (diff < best);
    end

    // Pass sequencer: per-M division, then the N sweep with best tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SW_IDLE;
            ref_q  <= '0;
            tgt    <= '0;
            best   <= '0;
            m      <= '0;
            n      <= '0;
            q      <= '0;
            r      <= '0;
            qs     <= '0;
            rs     <= '0;
            m_o    <= '0;
            n_o    <= '0;
            freq_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                SW_IDLE: begin
                    if (go_i) begin
                        ref_q  <= ref_i;
                        tgt    <= target_i;
                        best   <= target_i;
                        m_o    <= '0;
                        n_o    <= '0;
                        freq_o <= '0;
                        m      <= M_W'(M_MIN);
                        state  <= SW_DIV_GO;
                    end
                end
                SW_DIV_GO: state <= SW_DIV_WAIT;
                SW_DIV_WAIT: begin
                    if (div_done) begin
                        qs    <= div_q;
                        rs    <= div_r;
                        q     <= '0;
                        r     <= '0;
                        n     <= '0;
                        state <= SW_STEP;
                    end
                end
                SW_STEP: begin
                    q <= q_next;
                    r <= r_next;
                    n <= n_next;
                    if (take) begin
                        best   <= diff;
                        m_o    <= m;
                        n_o    <= n_next;
                        freq_o <= q_next;
                    end
                    if (n_next == N_W'(N_MAX)) begin
                        if (m == M_W'(M_MAX)) begin
                            state  <= SW_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            m     <= m + 1'b1;
                            state <= SW_DIV_GO;
                        end
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    // R2
    m_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_STEP) |-> (m >= M_W'(M_MIN) && m <= M_W'(M_MAX)));
    // R3
    best_below_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_o != '0) |-> (freq_o < tgt));
    // R5
    empty_pass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_o == '0) |-> (freq_o == '0 && n_o == '0));
endmodule

// File: rtl/pfs_pick.sv
// Chooses between the single- and doubled-reference pass results.
// The doubled result wins only when it is strictly higher.
module pfs_pick #(
    parameter int FREQ_W = 64,
    parameter int M_W    = 4,
    parameter int N_W    = 7
) (
    input  logic [FREQ_W-1:0] s_freq_i,
    input  logic [M_W-1:0]    s_m_i,
    input  logic [N_W-1:0]    s_n_i,
    input  logic [FREQ_W-1:0] d_freq_i,
    input  logic [M_W-1:0]    d_m_i,
    input  logic [N_W-1:0]    d_n_i,
    output logic              dbl_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic [M_W-1:0]    m_o,
    output logic [N_W-1:0]    n_o
);
    // Strict comparison keeps the single reference on a tie
    always_comb begin
        dbl_o  = (d_freq_i > s_freq_i);
        freq_o = dbl_o ? d_freq_i : s_freq_i;
        m_o    = dbl_o ? d_m_i    : s_m_i;
        n_o    = dbl_o ? d_n_i    : s_n_i;
    end
endmodule

// File: rtl/pll_factor_search.sv
// Top of the PLL factor search engine. It latches the target on start, runs
// the sweep with the base reference and then with twice that reference,
// and registers the better result with a one-cycle done pulse.
// Assumes 2*REF_HZ fits in REF_W bits. A start while busy is ignored.
module pll_factor_search
    import pfs_pkg::*;
#(
    parameter int FREQ_W = 64,
    parameter int REF_W  = 32,
    parameter int REF_HZ = 3_000_000,
    parameter int M_MIN  = 1,
    parameter int M_MAX  = 15,
    parameter int N_MIN  = 9,
    parameter int N_MAX  = 127
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [FREQ_W-1:0]               target_i,
    output logic                            busy_o,
    output logic                            done_o,
    output logic [$clog2(M_MAX+1)-1:0]      m_o,
    output logic [$clog2(N_MAX+1)-1:0]      n_o,
    output logic [FREQ_W-1:0]               freq_o,
    output logic                            dbl_o
);
    localparam int M_W = $clog2(M_MAX + 1);
    localparam int N_W = $clog2(N_MAX + 1);
    localparam logic [REF_W-1:0] REF_SINGLE = REF_W'(REF_HZ);
    localparam logic [REF_W-1:0] REF_DOUBLE = REF_W'(2 * REF_HZ);

    top_state_t        state;
    logic [FREQ_W-1:0] tgt_q;
    logic              sw_go;
    logic [REF_W-1:0]  sw_ref;
    logic              sw_done;
    logic [M_W-1:0]    sw_m;
    logic [N_W-1:0]    sw_n;
    logic [FREQ_W-1:0] sw_f;
    logic [M_W-1:0]    p1_m;
    logic [N_W-1:0]    p1_n;
    logic [FREQ_W-1:0] p1_f;
    logic              pk_dbl;
    logic [FREQ_W-1:0] pk_f;
    logic [M_W-1:0]    pk_m;
    logic [N_W-1:0]    pk_n;

    assign busy_o = (state != TP_IDLE);
    assign sw_ref = (state == TP_PASS2) ? REF_DOUBLE : REF_SINGLE;

    pfs_sweep #(
        .FREQ_W(FREQ_W), .REF_W(REF_W), .M_MIN(M_MIN), .M_MAX(M_MAX),
        .N_MIN(N_MIN), .N_MAX(N_MAX), .M_W(M_W), .N_W(N_W)
    ) sweep_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (sw_go),
        .ref_i    (sw_ref),
        .target_i (tgt_q),
        .done_o   (sw_done),
        .m_o      (sw_m),
        .n_o      (sw_n),
        .freq_o   (sw_f)
    );

    pfs_pick #(.FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W)) pick_i (
        .s_freq_i (p1_f),
        .s_m_i    (p1_m),
        .s_n_i    (p1_n),
        .d_freq_i (sw_f),
        .d_m_i    (sw_m),
        .d_n_i    (sw_n),
        .dbl_o    (pk_dbl),
        .freq_o   (pk_f),
        .m_o      (pk_m),
        .n_o      (pk_n)
    );

    // Pass sequencing, first-pass storage and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TP_IDLE;
            tgt_q  <= '0;
            sw_go  <= 1'b0;
            p1_m   <= '0;
            p1_n   <= '0;
            p1_f   <= '0;
            m_o    <= '0;
            n_o    <= '0;
            freq_o <= '0;
            dbl_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            sw_go  <= 1'b0;
            done_o <= 1'b0;
            case (state)
                TP_IDLE: begin
                    if (start_i) begin
                        tgt_q <= target_i;
                        sw_go <= 1'b1;
                        state <= TP_PASS1;
                    end
                end
                TP_PASS1: begin
                    if (sw_done) begin
                        p1_m  <= sw_m;
                        p1_n  <= sw_n;
                        p1_f  <= sw_f;
                        sw_go <= 1'b1;
                        state <= TP_PASS2;
                    end
                end
                TP_PASS2: begin
                    if (sw_done) begin
                        m_o    <= pk_m;
                        n_o    <= pk_n;
                        freq_o <= pk_f;
                        dbl_o  <= pk_dbl;
                        done_o <= 1'b1;
                        state  <= TP_IDLE;
                    end
                end
                default: state <= TP_IDLE;
            endcase
        end
    end

    // R8
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(tgt_q));
    // R6
    double_beats_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dbl_o) |-> (freq_o > p1_f));
endmodule

// File: tb/pll_factor_search_tb.sv
module pll_factor_search_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] target_i = '0;
    logic        busy_o, done_o, dbl_o;
    logic [3:0]  m_o;
    logic [6:0]  n_o;
    logic [63:0] freq_o;

    int checks = 0;
    int fails  = 0;
    longint cycles = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    pll_factor_search dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
        .busy_o(busy_o), .done_o(done_o), .m_o(m_o), .n_o(n_o),
        .freq_o(freq_o), .dbl_o(dbl_o)
    );

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Exhaustive single-pass model from the requirements
    task automatic model_pass(input longint unsigned tgt, input longint unsigned rf,
                              output int bm, output int bn, output longint unsigned bf);
        longint unsigned best = tgt;
        bm = 0; bn = 0; bf = 0;
        for (int m = 1; m <= 15; m++)
            for (int n = 9; n <= 127; n++) begin
                longint unsigned c = (longint'(n) * rf) / longint'(m);
                if (c < tgt && (tgt - c) < best) begin
                    best = tgt - c; bm = m; bn = n; bf = c;
                end
            end
    endtask

    task automatic model(input longint unsigned tgt, output int em, output int en,
                         output longint unsigned ef, output int ed);
        int m1, n1, m2, n2;
        longint unsigned f1, f2;
        model_pass(tgt, 3000000, m1, n1, f1);
        model_pass(tgt, 6000000, m2, n2, f2);
        if (f2 > f1) begin em = m2; en = n2; ef = f2; ed = 1; end
        else begin em = m1; en = n1; ef = f1; ed = 0; end
    endtask

    task automatic wait_done(input string req);
        int guard = 0;
        while (!done_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (!done_o) begin
            fails++; checks++;
            $display("FAIL %s watchdog: actual 0 expected done", req);
        end
    endtask

    task automatic pulse_start(input longint unsigned tgt);
        @(negedge clk);
        start_i = 1'b1; target_i = tgt;
        @(negedge clk);
        start_i = 1'b0; target_i = '0;
    endtask

    // Run one search and compare the whole result against the model
    task automatic run_case(input longint unsigned tgt, input string req);
        int em, en, ed;
        longint unsigned ef;
        logic [63:0] hold_f;
        model(tgt, em, en, ef, ed);
        pulse_start(tgt);
        check("R8", "busy after start", busy_o, 1);
        wait_done(req);
        check(req, "m", m_o, em);
        check(req, "n", n_o, en);
        check(req, "freq", freq_o, ef);
        check(req, "dbl", dbl_o, ed);
        if (m_o != 0)
            check("R2", "freq formula", freq_o,
                  (longint'(n_o) * (dbl_o ? 6000000 : 3000000)) / longint'(m_o));
        check("R3", "strictly below", (m_o == 0) || (freq_o < tgt), 1);
        hold_f = freq_o;
        @(negedge clk);
        check("R8", "done one cycle", done_o, 0);
        check("R8", "busy cleared", busy_o, 0);
        check("R8", "freq held", freq_o, hold_f);
    endtask

    task automatic t_reset();
        check("R1", "busy", busy_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "m", m_o, 0);
        check("R1", "n", n_o, 0);
        check("R1", "freq", freq_o, 0);
        check("R1", "dbl", dbl_o, 0);
    endtask

    task automatic t_typical();
        run_case(64'd25175000, "R4");
        run_case(64'd74250000, "R4");
    endtask

    task automatic t_exact();
        // 27 MHz = 9 x 3 MHz / 1 exactly: must be skipped
        run_case(64'd27000000, "R3");
        check("R3", "exact excluded", freq_o != 64'd27000000, 1);
    endtask

    task automatic t_empty();
        run_case(64'd1, "R5");
        check("R5", "empty m", m_o, 0);
        run_case(64'd1800000, "R5");
        check("R5", "empty at min", freq_o, 0);
        // Only the single pass finds 1.8 MHz, the doubled pass finds none
        run_case(64'd1800001, "R5");
        check("R5", "single only", freq_o, 1800000);
    endtask

    task automatic t_choose();
        // Both passes reach 100 MHz: tie keeps single reference
        run_case(64'd100000001, "R6");
        check("R6", "tie keeps single", dbl_o, 0);
        check("R4", "tie earliest m", m_o, 3);
        check("R4", "tie earliest n", n_o, 100);
        run_case(64'd1000000000, "R6");
        check("R6", "high target dbl", dbl_o, 1);
        run_case(64'd148500000, "R6");
    endtask

    task automatic t_busy_ignore();
        int em, en, ed;
        longint unsigned ef;
        model(64'd33000000, em, en, ef, ed);
        pulse_start(64'd33000000);
        repeat (100) @(negedge clk);
        start_i = 1'b1; target_i = 64'd5000000;
        @(negedge clk);
        start_i = 1'b0; target_i = '0;
        wait_done("R7");
        check("R7", "freq of first target", freq_o, ef);
        check("R7", "m of first target", m_o, em);
        @(negedge clk);
        check("R7", "no second run", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_typical();
        t_exact();
        t_empty();
        t_choose();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        fails++; checks++;
        $display("FAIL global watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule